// File: doc/BRIEF.md
# LED Dot Matrix Column Scanner

This block lights a 7-row by 5-column LED dot matrix by strobing one column at a time. The column-select bus is active low and carries a single zero that walks from column 1 to column 5 and then wraps back to column 1. While a column is selected, the row bus carries that column's bitmap, taken from a small built-in table of four glyphs. A row line driven high together with a column line driven low lights the LED where they cross. Repeating the scan makes the whole character appear lit.

Each column stays selected for `DWELL_CYCLES` clock cycles. By default this is `CLK_HZ/1000`, which gives about one millisecond per column. Between two columns, and before the first column after enable, the scanner inserts one blank cycle in which every column is deselected and the rows are low, so that the previous column's data never shows on the next column. The glyph select input is sampled only at the start of each full scan.

The controller is a three-state machine:

- **IDLE**: dark. It is held by reset or by a low enable.
- **BLANK**: one dark cycle.
- **SHOW**: one column is driven.

The transitions are:

- IDLE→BLANK when enabled.
- BLANK→SHOW always. This is where the glyph is latched if the next column is column 1.
- SHOW→SHOW while the dwell count runs.
- SHOW→BLANK when the dwell count expires. The column index advances and wraps from 5 to 1 here.
- Any state→IDLE on reset or when enable is low.

Top module: `dmx_column_scanner`

## Requirements
- R1: While `rst_i` is high, or `en_i` is low, `col_n_o` is 5'b11111 and `row_o` is 0 in the same cycle.
- R2: While a column is shown, exactly one bit of `col_n_o` is low. Column k (1..5) is shown as bit k-1 low, so column 1 is 5'b11110 and column 5 is 5'b01111.
- R3: Columns are shown in the order 1,2,3,4,5 and then 1 again, without end, while enabled.
- R4: `row_o` bit 0 is the top row. For columns 1..5 the row bus carries the following patterns: glyph 0 = 7E,11,11,11,7E; glyph 1 = 7F,08,08,08,7F; glyph 2 = 7F,49,49,49,41; glyph 3 = 7F,40,40,40,40 (hex).
- R5: Each column is shown for exactly `DWELL_CYCLES` consecutive cycles.
- R6: Exactly one blank cycle (`col_n_o` all ones, `row_o` 0) precedes every column shown.
- R7: `glyph_sel_i` is sampled in the blank cycle before column 1, on the clock edge that starts column 1. A change at any other time does not affect the scan in progress.
- R8: After `en_i` rises, the outputs stay dark for one cycle, then give one blank cycle, then show column 1. Dropping `en_i` mid-scan makes the next enable restart from column 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Scan enable |
| glyph_sel_i | input | 2 | Glyph code, 0..3 |
| row_o | output | 7 | Row data, active high, bit 0 = top row |
| col_n_o | output | 5 | Column select, active low, bit 0 = column 1 |

## Verification
The scoreboard predicts every output cycle, so a dwell one cycle too long or too short, or a missing or doubled blank cycle, shows up as a shifted sequence. The bench changes the glyph select in the middle of a scan. A design that samples it on every column would then mix two glyphs within one frame. The bench also drops enable in the middle of column 2. A design that resumes from its old column index, rather than from column 1, fails the check that follows. The wrap from column 5 to column 1 is exercised across several frames, which catches an index that runs into a sixth, undefined column.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
    localparam int MTX_ROWS   = 7;
    localparam int MTX_COLS   = 5;
    localparam int GLYPH_NUM  = 4;
    localparam int GLYPH_W    = $clog2(GLYPH_NUM);
    localparam int COL_IDX_W  = $clog2(MTX_COLS);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLANK = 2'd1,
        ST_SHOW  = 2'd2
    } scan_state_e;
endpackage

// File: rtl/dmx_glyph_rom.sv
module dmx_glyph_rom
    import dmx_pkg::*;
(
    input  logic [GLYPH_W-1:0]   glyph_i,
    input  logic [COL_IDX_W-1:0] col_idx_i,
    output logic [MTX_ROWS-1:0]  bits_o
);
    // Left-to-right column bitmaps, row 0 in bit 0.
    always_comb begin
        bits_o = '0;
        unique case (glyph_i)
            2'd0: case (col_idx_i)
                3'd0, 3'd4: bits_o = 7'h7E;
                3'd1, 3'd2, 3'd3: bits_o = 7'h11;
                default: bits_o = '0;
            endcase
            2'd1: case (col_idx_i)
                3'd0, 3'd4: bits_o = 7'h7F;
                3'd1, 3'd2, 3'd3: bits_o = 7'h08;
                default: bits_o = '0;
            endcase
            2'd2: case (col_idx_i)
                3'd0: bits_o = 7'h7F;
                3'd1, 3'd2, 3'd3: bits_o = 7'h49;
                3'd4: bits_o = 7'h41;
                default: bits_o = '0;
            endcase
            2'd3: case (col_idx_i)
                3'd0: bits_o = 7'h7F;
                3'd1, 3'd2, 3'd3, 3'd4: bits_o = 7'h40;
                default: bits_o = '0;
            endcase
            default: bits_o = '0;
        endcase
    end
endmodule

// File: rtl/dmx_col_decode.sv
module dmx_col_decode
    import dmx_pkg::*;
(
    input  logic                 active_i,
    input  logic [COL_IDX_W-1:0] col_idx_i,
    output logic [MTX_COLS-1:0]  col_n_o
);
    for (genvar g = 0; g < MTX_COLS; g++) begin : g_col
        assign col_n_o[g] = !(active_i && (col_idx_i == COL_IDX_W'(g)));
    end
endmodule

// File: rtl/dmx_scan_fsm.sv
module dmx_scan_fsm
    import dmx_pkg::*;
#(
    parameter int DWELL_CYCLES = 50_000
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic [GLYPH_W-1:0]   glyph_sel_i,
    output logic                 active_o,
    output logic [COL_IDX_W-1:0] col_idx_o,
    output logic [GLYPH_W-1:0]   glyph_o
);
    localparam int CNT_W = $clog2(DWELL_CYCLES + 1);
    localparam logic [CNT_W-1:0]     CNT_LAST = CNT_W'(DWELL_CYCLES - 1);
    localparam logic [COL_IDX_W-1:0] IDX_LAST = COL_IDX_W'(MTX_COLS - 1);

    scan_state_e          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [COL_IDX_W-1:0] idx_q;
    logic [GLYPH_W-1:0]   glyph_q;
    logic                 dwell_done;

    assign dwell_done = (cnt_q == CNT_LAST);

    // State register
    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) state_q <= ST_IDLE;
        else                state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_BLANK;
            ST_BLANK: state_d = ST_SHOW;
            ST_SHOW:  state_d = dwell_done ? ST_BLANK : ST_SHOW;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Counter, column index, latched glyph
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            glyph_q <= '0;
        end else if (!en_i) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    idx_q <= '0;
                end
                ST_BLANK: begin
                    cnt_q <= '0;
                    if (idx_q == '0) glyph_q <= glyph_sel_i;
                end
                ST_SHOW: begin
                    if (dwell_done) begin
                        cnt_q <= '0;
                        idx_q <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Outputs
    always_comb begin
        active_o  = (state_q == ST_SHOW) && en_i && !rst_i;
        col_idx_o = idx_q;
        glyph_o   = glyph_q;
    end

    AST_DWELL_BOUND: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SHOW) |-> (cnt_q < CNT_W'(DWELL_CYCLES))); // R5
    AST_BLANK_AFTER_DWELL: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SHOW && dwell_done && en_i) |=> !active_o); // R6
    AST_COL_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_SHOW && dwell_done && en_i && idx_q == IDX_LAST) |=> (idx_q == '0)); // R3
    AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        idx_q <= IDX_LAST); // R3
    AST_GLYPH_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !(state_q == ST_BLANK && idx_q == '0) |=> $stable(glyph_q)); // R7
endmodule

// File: rtl/dmx_column_scanner.sv
module dmx_column_scanner
    import dmx_pkg::*;
#(
    parameter int CLK_HZ       = 50_000_000,
    parameter int DWELL_CYCLES = CLK_HZ / 1000
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                en_i,
    input  logic [GLYPH_W-1:0]  glyph_sel_i,
    output logic [MTX_ROWS-1:0] row_o,
    output logic [MTX_COLS-1:0] col_n_o
);
    logic                 active;
    logic [COL_IDX_W-1:0] col_idx;
    logic [GLYPH_W-1:0]   glyph;
    logic [MTX_ROWS-1:0]  rom_bits;

    dmx_scan_fsm #(.DWELL_CYCLES(DWELL_CYCLES)) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .en_i        (en_i),
        .glyph_sel_i (glyph_sel_i),
        .active_o    (active),
        .col_idx_o   (col_idx),
        .glyph_o     (glyph)
    );

    dmx_glyph_rom u_rom (
        .glyph_i   (glyph),
        .col_idx_i (col_idx),
        .bits_o    (rom_bits)
    );

    dmx_col_decode u_dec (
        .active_i  (active),
        .col_idx_i (col_idx),
        .col_n_o   (col_n_o)
    );

    assign row_o = active ? rom_bits : '0;

    AST_ONE_COLUMN: assert property (@(posedge clk_i) disable iff (rst_i)
        (row_o != '0) |-> ($countones(~col_n_o) == 1)); // R2
    AST_SELECT_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(~col_n_o)); // R2
    AST_DARK_WHEN_OFF: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |-> (col_n_o == '1 && row_o == '0)); // R1
endmodule

// File: tb/tb_dmx_column_scanner.sv
module tb_dmx_column_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en  = 1'b0;
    logic [1:0] gsel = 2'd0;
    logic [6:0] row;
    logic [4:0] col_n;

    int total = 0;
    int bad = 0;

    typedef struct {
        logic [4:0] col;
        logic [6:0] row;
        string      tag;
    } item_t;
    item_t exp_q[$];

    dmx_column_scanner #(.CLK_HZ(6000), .DWELL_CYCLES(DW)) dut (
        .clk_i(clk), .rst_i(rst), .en_i(en), .glyph_sel_i(gsel),
        .row_o(row), .col_n_o(col_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [6:0] glyph_bits(input int g, input int c);
        logic [6:0] t [4][5];
        t[0] = '{7'h7E, 7'h11, 7'h11, 7'h11, 7'h7E};
        t[1] = '{7'h7F, 7'h08, 7'h08, 7'h08, 7'h7F};
        t[2] = '{7'h7F, 7'h49, 7'h49, 7'h49, 7'h41};
        t[3] = '{7'h7F, 7'h40, 7'h40, 7'h40, 7'h40};
        return t[g][c];
    endfunction

    function automatic logic [4:0] col_pat(input int c);
        return 5'h1F ^ (5'd1 << c);
    endfunction

    task automatic push(input logic [4:0] c, input logic [6:0] r, input string tag);
        item_t it;
        it.col = c; it.row = r; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic push_dark(input int n, input string tag);
        for (int i = 0; i < n; i++) push(5'h1F, 7'h00, tag);
    endtask

    task automatic push_frame(input int g, input string tag);
        for (int c = 0; c < 5; c++) begin
            push(5'h1F, 7'h00, "R6 blank");
            for (int d = 0; d < DW; d++) push(col_pat(c), glyph_bits(g, c), tag);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check_now(input logic [4:0] c, input logic [6:0] r, input string tag);
        total++;
        if (col_n !== c || row !== r) begin
            bad++;
            $display("FAIL %s: actual col=%b row=%h expected col=%b row=%h", tag, col_n, row, c, r);
        end
    endtask

    // Monitor: compare one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            item_t it;
            it = exp_q.pop_front();
            total++;
            if (col_n !== it.col || row !== it.row) begin
                bad++;
                $display("FAIL %s @%0t: actual col=%b row=%h expected col=%b row=%h",
                         it.tag, $time, col_n, row, it.col, it.row);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL R5 watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: dark during reset, even with enable high
        @(negedge clk); check_now(5'h1F, 7'h00, "R1 reset");
        en = 1'b1;
        @(negedge clk); check_now(5'h1F, 7'h00, "R1 reset with enable");
        @(posedge clk); #1;
        en = 1'b0;
        rst = 1'b0;
        push_dark(3, "R1 disabled");
        cycles(3);

        // Three frames; glyph changes inside frames apply at the next column 1 (R7)
        gsel = 2'd0;
        en = 1'b1;
        push_dark(1, "R8 first dark");
        push_frame(0, "R2 R3 R4 R5 glyph0");
        push_frame(1, "R7 glyph1");
        push_frame(3, "R7 glyph3");
        cycles(10);
        gsel = 2'd1;
        cycles(36);
        gsel = 2'd3;
        cycles(60);
        en = 1'b0;
        push_dark(3, "R1 enable low");
        cycles(3);

        // Drop enable inside column 2, then restart from column 1 (R8)
        gsel = 2'd2;
        en = 1'b1;
        push_dark(1, "R8 dark");
        push(5'h1F, 7'h00, "R6 blank");
        for (int d = 0; d < DW; d++) push(col_pat(0), glyph_bits(2, 0), "R8 col1");
        push(5'h1F, 7'h00, "R6 blank");
        for (int d = 0; d < 3; d++) push(col_pat(1), glyph_bits(2, 1), "R8 col2");
        cycles(12);
        en = 1'b0;
        push_dark(2, "R8 dropped");
        cycles(2);
        en = 1'b1;
        push_dark(1, "R8 restart dark");
        push_frame(2, "R8 R4 restart glyph2");
        cycles(36);
        en = 1'b0;
        push_dark(1, "R1 final");
        cycles(3);

        while (exp_q.size() != 0) @(posedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule